// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is a synthesizable behavioural model of a parallel NOR flash driven through a simple synchronous bus. Reads and writes are single-cycle strobes on a byte address. A small word array held in inferred block RAM holds the contents. Multi-cycle write sequences are decoded one bus cycle at a time. Each step is checked against two configurable unlock word offsets and an 8-bit command code taken from the low byte of the write data. The recognised sequences are word program, sector erase, chip erase, identifier read, query mode and a bypass shortcut for repeated programming.

Depending on its mode, a read returns one of four things: array data, an identifier word, a polled status byte, or a byte fetched through a constant-table port from a query ROM outside the block. Program and erase make the block busy for a parameter-defined number of clock cycles. An erase fills its range with ones, one word per cycle, in the early part of that busy window. Software is expected to poll the status byte until array data comes back.

Top module: `nor_flash_seq`

## Requirements
- R1: After reset the block is in array-read mode with bypass off, and any half-entered sequence is discarded. A read strobe in cycle t delivers its word on `rdata` after the next rising edge.
- R2: A normal sequence opens with data 0xAA at word offset UNLOCK_A, followed by 0x55 at UNLOCK_B. Offsets are taken within a sector. Any other write at either step returns to array-read mode.
- R3: The third write must be at UNLOCK_A. Its code selects the command: 0x80 erase setup, 0x90 identifier mode, 0xA0 program, 0x20 enter bypass. A wrong address or any other code returns to array-read mode.
- R4: A write whose low byte is 0xF0 returns to array-read mode and clears bypass from every idle state. The one exception is the pending program data write, where 0xF0 is programmed as data.
- R5: Program stores the bitwise AND of the data and the old word, so bits only go from 1 to 0.
- R6: While busy, a read returns a status byte in `rdata[7:0]` with the upper bits zero, and bit 6 inverts after every status read. Bits 5..0 read 0. For program, bit 7 is the complement of data bit 7. For erase, bit 7 reads 0.
- R7: After erase setup and a second unlock pair, code 0x30 at any word of a sector fills that whole sector with ones. Other sectors are untouched.
- R8: In the same position, code 0x10 at UNLOCK_A fills the whole array with ones. Code 0x10 at any other offset returns to array-read mode without erasing.
- R9: While busy, every write is ignored, 0xF0 included. Busy lasts PROG_CYC cycles for program, SECT_ERASE_CYC for sector erase and CHIP_ERASE_CYC for chip erase. Afterwards the block returns to array-read mode, or to bypass command mode if bypass is on.
- R10: In identifier mode, reads depend on the word offset (low 8 bits). Offset 0 returns ID_MFR, 1 returns ID_DEV and 2 returns 0. Offsets 0x0E and 0x0F return ID_EXT0 and ID_EXT1 unless that word is all ones, in which case array data is returned. All other offsets return array data.
- R11: Data 0x98 at sector offset 0x55 enters query mode, from array-read or identifier mode. There, `cfi_idx` carries the word offset's low 8 bits. A read returns `cfi_byte`, or 0 when the index is CFI_LEN or more. Any write leaves query mode to array-read mode.
- R12: In bypass mode, program needs only 0xA0 at any address and then the data write. After the program completes, the block stays in bypass. The pair 0x90 then 0x00 leaves bypass.
- R13: The word offset is the byte address taken modulo the chip size and shifted right by log2 of the bytes per word. Higher address bits alias, and low byte-lane bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | BUS_AW | Byte address |
| wdata | input | DATA_W | Write data; low byte is the command code |
| rdata | output | DATA_W | Read data, valid the cycle after a read strobe |
| cfi_idx | output | 8 | Index into the external query table |
| cfi_byte | input | 8 | Query table byte at `cfi_idx` |

## Verification
The bench builds the block with a 16-bit word, four sectors of 128 words, and a 12-bit byte address bus over a 1 KiB array. The 12-bit bus makes two alias bits and the byte-lane bit available for every access. The erase counts are 600 and 200 cycles and program takes 8 cycles, so a full chip sweep and several sector sweeps fit in a short run. The two extended identifier words are set so that one returns itself and the other, being all ones, exercises the fall-back to array data.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [3:0] {
    ST_ARRAY,
    ST_UNL_B,
    ST_CMD,
    ST_ER_UNL_A,
    ST_ER_UNL_B,
    ST_ER_CMD,
    ST_PGM_DATA,
    ST_PGM_WB,
    ST_BUSY,
    ST_AUTOSEL,
    ST_QUERY
  } seq_state_t;

  localparam logic [7:0] C_KEY1      = 8'hAA;
  localparam logic [7:0] C_KEY2      = 8'h55;
  localparam logic [7:0] C_ERASE_SET = 8'h80;
  localparam logic [7:0] C_IDENT     = 8'h90;
  localparam logic [7:0] C_PROGRAM   = 8'hA0;
  localparam logic [7:0] C_BYPASS    = 8'h20;
  localparam logic [7:0] C_ABORT     = 8'hF0;
  localparam logic [7:0] C_QUERY     = 8'h98;
  localparam logic [7:0] C_CHIP      = 8'h10;
  localparam logic [7:0] C_SECTOR    = 8'h30;
  localparam logic [7:0] C_BYP_EXIT  = 8'h00;

endpackage

// File: rtl/nor_word_store.sv
module nor_word_store #(
  parameter int WORDS  = 512,
  parameter int DATA_W = 16,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rq,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wd
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
    if (re) rq <= mem[raddr];
  end

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int AW = 9,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] load,
  input  logic          sweep_go,
  input  logic [AW-1:0] sweep_base,
  input  logic [AW:0]   sweep_len,
  output logic          busy,
  output logic          done,
  output logic          swp_we,
  output logic [AW-1:0] swp_addr
);

  logic [CW-1:0] cnt_q;
  logic [AW:0]   scnt_q, slen_q;
  logic [AW-1:0] sbase_q;
  logic          sact_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      scnt_q  <= '0;
      slen_q  <= '0;
      sbase_q <= '0;
      sact_q  <= 1'b0;
    end else begin
      if (start) cnt_q <= load;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;

      if (start && sweep_go) begin
        sact_q  <= 1'b1;
        scnt_q  <= '0;
        slen_q  <= sweep_len;
        sbase_q <= sweep_base;
      end else if (sact_q) begin
        scnt_q <= scnt_q + 1'b1;
        if (scnt_q == slen_q - 1'b1) sact_q <= 1'b0;
      end
    end
  end

  assign busy     = (cnt_q != '0);
  assign done     = (cnt_q == CW'(1));
  assign swp_we   = sact_q;
  assign swp_addr = sbase_q + scnt_q[AW-1:0];

  // the sequencer never starts a new operation while one runs
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // the fill sweep is finished before the busy window closes
  assert_sweep_before_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !swp_we);

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int WW           = 9,
  parameter int SW           = 7,
  parameter int CW           = 10,
  parameter int UNLOCK_A     = 'h55,
  parameter int UNLOCK_B     = 'h2A,
  parameter int QUERY_OFF    = 'h55,
  parameter int SECTOR_WORDS = 128,
  parameter int CHIP_WORDS   = 512,
  parameter int CHIP_LOAD    = 600,
  parameter int SECT_LOAD    = 200,
  parameter int PROG_LOAD    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WW-1:0]     woff,
  input  logic [DATA_W-1:0] mem_q,
  input  logic              tmr_busy,
  input  logic              tmr_done,
  output seq_state_t        state_o,
  output logic [7:0]        status_o,
  output logic              pgm_we,
  output logic [WW-1:0]     pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  output logic              tmr_start,
  output logic [CW-1:0]     tmr_load,
  output logic              sweep_go,
  output logic [WW-1:0]     sweep_base,
  output logic [WW:0]       sweep_len
);

  seq_state_t        state_q, state_n;
  logic              bypass_q, bypass_n;
  logic [7:0]        status_q;
  logic [WW-1:0]     paddr_q;
  logic [DATA_W-1:0] pdata_q;
  logic              capture;
  logic [7:0]        cmd;
  logic [SW-1:0]     loc;
  logic              rd_busy;

  assign cmd     = wdata[7:0];
  assign loc     = woff[SW-1:0];
  assign rd_busy = rd_en && (state_q == ST_PGM_WB || state_q == ST_BUSY);

  always_comb begin
    state_n    = state_q;
    bypass_n   = bypass_q;
    capture    = 1'b0;
    tmr_start  = 1'b0;
    tmr_load   = '0;
    sweep_go   = 1'b0;
    sweep_base = '0;
    sweep_len  = '0;
    case (state_q)
      ST_BUSY: if (tmr_done) state_n = bypass_q ? ST_CMD : ST_ARRAY;
      ST_PGM_WB: begin
        tmr_start = 1'b1;
        tmr_load  = CW'(PROG_LOAD);
        state_n   = ST_BUSY;
      end
      default: if (wr_en) begin
        if (cmd == C_ABORT && state_q != ST_PGM_DATA) begin
          state_n  = ST_ARRAY;
          bypass_n = 1'b0;
        end else begin
          // any unlisted write aborts to array mode
          state_n  = ST_ARRAY;
          bypass_n = 1'b0;
          case (state_q)
            ST_ARRAY: begin
              if (loc == SW'(QUERY_OFF) && cmd == C_QUERY) state_n = ST_QUERY;
              else if (loc == SW'(UNLOCK_A) && cmd == C_KEY1) state_n = ST_UNL_B;
            end
            ST_UNL_B:
              if (loc == SW'(UNLOCK_B) && cmd == C_KEY2) state_n = ST_CMD;
            ST_CMD: if (bypass_q || loc == SW'(UNLOCK_A)) begin
              bypass_n = bypass_q;
              case (cmd)
                C_BYPASS:    begin bypass_n = 1'b1; state_n = ST_CMD; end
                C_ERASE_SET: state_n = ST_ER_UNL_A;
                C_IDENT:     state_n = ST_AUTOSEL;
                C_PROGRAM:   state_n = ST_PGM_DATA;
                default:     bypass_n = 1'b0;
              endcase
            end
            ST_ER_UNL_A: if (loc == SW'(UNLOCK_A) && cmd == C_KEY1) begin
              state_n = ST_ER_UNL_B; bypass_n = bypass_q;
            end
            ST_ER_UNL_B: if (loc == SW'(UNLOCK_B) && cmd == C_KEY2) begin
              state_n = ST_ER_CMD; bypass_n = bypass_q;
            end
            ST_ER_CMD: begin
              if (cmd == C_CHIP && loc == SW'(UNLOCK_A)) begin
                tmr_start = 1'b1;
                tmr_load  = CW'(CHIP_LOAD);
                sweep_go  = 1'b1;
                sweep_len = (WW+1)'(CHIP_WORDS);
                state_n   = ST_BUSY;
                bypass_n  = bypass_q;
              end else if (cmd == C_SECTOR) begin
                tmr_start  = 1'b1;
                tmr_load   = CW'(SECT_LOAD);
                sweep_go   = 1'b1;
                sweep_base = woff & ~WW'(SECTOR_WORDS - 1);
                sweep_len  = (WW+1)'(SECTOR_WORDS);
                state_n    = ST_BUSY;
                bypass_n   = bypass_q;
              end
            end
            ST_PGM_DATA: begin
              capture  = 1'b1;
              state_n  = ST_PGM_WB;
              bypass_n = bypass_q;
            end
            ST_AUTOSEL:
              if (!(bypass_q && cmd == C_BYP_EXIT) &&
                  loc == SW'(QUERY_OFF) && cmd == C_QUERY) state_n = ST_QUERY;
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_ARRAY;
      bypass_q <= 1'b0;
      status_q <= '0;
      paddr_q  <= '0;
      pdata_q  <= '0;
    end else begin
      state_q  <= state_n;
      bypass_q <= bypass_n;
      if (capture) begin
        paddr_q  <= woff;
        pdata_q  <= wdata;
        status_q <= {~wdata[7], 7'b0};
      end else if (sweep_go) begin
        status_q <= 8'h00;
      end else begin
        status_q <= status_q ^ {tmr_done, rd_busy, 6'b0};
      end
    end
  end

  assign state_o  = state_q;
  assign status_o = status_q;
  assign pgm_we   = (state_q == ST_PGM_WB);
  assign pgm_addr = paddr_q;
  assign pgm_data = mem_q & pdata_q;

  assert_bypass_entry_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(bypass_q) |-> $past(state_q == ST_CMD && wr_en && wdata[7:0] == C_BYPASS));

  assert_busy_has_timer_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY) |-> tmr_busy);

  assert_status_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state_q == ST_BUSY) |=> (status_q[6] != $past(status_q[6])));

endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq
  import nor_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int BUS_AW         = 12,
  parameter int SECTOR_WORDS   = 128,
  parameter int SECTORS        = 4,
  parameter int UNLOCK_A       = 'h55,
  parameter int UNLOCK_B       = 'h2A,
  parameter int QUERY_OFF      = 'h55,
  parameter int CFI_LEN        = 64,
  parameter int CHIP_ERASE_CYC = 600,
  parameter int SECT_ERASE_CYC = 200,
  parameter int PROG_CYC       = 8,
  parameter logic [DATA_W-1:0] ID_MFR  = 16'h0001,
  parameter logic [DATA_W-1:0] ID_DEV  = 16'h227E,
  parameter logic [DATA_W-1:0] ID_EXT0 = 16'h2221,
  parameter logic [DATA_W-1:0] ID_EXT1 = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [7:0]        cfi_idx,
  input  logic [7:0]        cfi_byte
);

  localparam int BYTES      = DATA_W / 8;
  localparam int BSH        = $clog2(BYTES);
  localparam int CHIP_WORDS = SECTOR_WORDS * SECTORS;
  localparam int WW         = $clog2(CHIP_WORDS);
  localparam int SW         = $clog2(SECTOR_WORDS);
  localparam int ADDR_W     = WW + BSH;
  localparam int CHIP_LOAD  = (CHIP_ERASE_CYC > CHIP_WORDS) ? CHIP_ERASE_CYC : CHIP_WORDS + 1;
  localparam int SECT_LOAD  = (SECT_ERASE_CYC > SECTOR_WORDS) ? SECT_ERASE_CYC : SECTOR_WORDS + 1;
  localparam int PROG_LOAD  = (PROG_CYC > 1) ? PROG_CYC : 1;
  localparam int MAX_LOAD   = (CHIP_LOAD > SECT_LOAD) ?
                              ((CHIP_LOAD > PROG_LOAD) ? CHIP_LOAD : PROG_LOAD) :
                              ((SECT_LOAD > PROG_LOAD) ? SECT_LOAD : PROG_LOAD);
  localparam int CW         = $clog2(MAX_LOAD + 1);

  logic [WW-1:0]     woff;
  logic [7:0]        off8;
  logic [DATA_W-1:0] mem_q, pgm_data;
  logic [WW-1:0]     pgm_addr, swp_addr, sweep_base;
  logic [WW:0]       sweep_len;
  logic              pgm_we, swp_we, tmr_start, sweep_go, tmr_busy, tmr_done;
  logic [CW-1:0]     tmr_load;
  logic [7:0]        status;
  seq_state_t        state;

  assign woff = addr[ADDR_W-1:BSH];

  generate
    if (WW >= 8) begin : g_off_wide
      assign off8 = woff[7:0];
    end else begin : g_off_narrow
      assign off8 = {{(8-WW){1'b0}}, woff};
    end
  endgenerate

  assign cfi_idx = off8;

  nor_word_store #(.WORDS(CHIP_WORDS), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .re    (rd_en | wr_en),
    .raddr (woff),
    .rq    (mem_q),
    .we    (pgm_we | swp_we),
    .waddr (swp_we ? swp_addr : pgm_addr),
    .wd    (swp_we ? {DATA_W{1'b1}} : pgm_data)
  );

  nor_busy_timer #(.AW(WW), .CW(CW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (tmr_start),
    .load       (tmr_load),
    .sweep_go   (sweep_go),
    .sweep_base (sweep_base),
    .sweep_len  (sweep_len),
    .busy       (tmr_busy),
    .done       (tmr_done),
    .swp_we     (swp_we),
    .swp_addr   (swp_addr)
  );

  nor_seq_fsm #(
    .DATA_W(DATA_W), .WW(WW), .SW(SW), .CW(CW),
    .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B), .QUERY_OFF(QUERY_OFF),
    .SECTOR_WORDS(SECTOR_WORDS), .CHIP_WORDS(CHIP_WORDS),
    .CHIP_LOAD(CHIP_LOAD), .SECT_LOAD(SECT_LOAD), .PROG_LOAD(PROG_LOAD)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .woff       (woff),
    .mem_q      (mem_q),
    .tmr_busy   (tmr_busy),
    .tmr_done   (tmr_done),
    .state_o    (state),
    .status_o   (status),
    .pgm_we     (pgm_we),
    .pgm_addr   (pgm_addr),
    .pgm_data   (pgm_data),
    .tmr_start  (tmr_start),
    .tmr_load   (tmr_load),
    .sweep_go   (sweep_go),
    .sweep_base (sweep_base),
    .sweep_len  (sweep_len)
  );

  // read source chosen at the strobe, data lands one cycle later
  logic              from_arr_n, from_arr_q;
  logic [DATA_W-1:0] val_n, val_q;

  always_comb begin
    from_arr_n = 1'b1;
    val_n      = '0;
    case (state)
      ST_PGM_WB, ST_BUSY: begin
        from_arr_n = 1'b0;
        val_n      = DATA_W'(status);
      end
      ST_AUTOSEL: begin
        case (off8)
          8'h00: begin from_arr_n = 1'b0; val_n = ID_MFR; end
          8'h01: begin from_arr_n = 1'b0; val_n = ID_DEV; end
          8'h02: begin from_arr_n = 1'b0; val_n = '0; end
          8'h0E: if (ID_EXT0 != '1) begin from_arr_n = 1'b0; val_n = ID_EXT0; end
          8'h0F: if (ID_EXT1 != '1) begin from_arr_n = 1'b0; val_n = ID_EXT1; end
          default: ;
        endcase
      end
      ST_QUERY: begin
        from_arr_n = 1'b0;
        val_n      = (int'(off8) >= CFI_LEN) ? '0 : DATA_W'(cfi_byte);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      from_arr_q <= 1'b1;
      val_q      <= '0;
    end else if (rd_en) begin
      from_arr_q <= from_arr_n;
      val_q      <= val_n;
    end
  end

  assign rdata = from_arr_q ? mem_q : val_q;

  // status reads never carry anything above the low status bits
  assert_status_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state == ST_BUSY) |=> (rdata[5:0] == '0 && rdata[DATA_W-1:8] == '0));

endmodule

// File: tb/nor_flash_seq_tb.sv
module nor_flash_seq_tb;

  localparam int DW = 16, WORDS = 512, SECW = 128;
  localparam int UA = 'h55, UB = 'h2A, QOFF = 'h55, CFIL = 64;
  localparam int CHIPC = 600, SECTC = 200, PROGC = 8;
  localparam logic [15:0] IDM = 16'h0001, IDD = 16'h227E, IDX0 = 16'h2221, IDX1 = 16'hFFFF;

  logic clk = 1'b0, rst = 1'b1, rd_en = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  cfi_idx, cfi_byte;
  int errs = 0, checks = 0;
  logic [15:0] shadow [WORDS];

  always #10 clk = ~clk;
  assign cfi_byte = cfi_idx ^ 8'h5A;

  nor_flash_seq #(
    .DATA_W(DW), .BUS_AW(12), .SECTOR_WORDS(SECW), .SECTORS(4),
    .UNLOCK_A(UA), .UNLOCK_B(UB), .QUERY_OFF(QOFF), .CFI_LEN(CFIL),
    .CHIP_ERASE_CYC(CHIPC), .SECT_ERASE_CYC(SECTC), .PROG_CYC(PROGC),
    .ID_MFR(IDM), .ID_DEV(IDD), .ID_EXT0(IDX0), .ID_EXT1(IDX1)
  ) u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cfi_idx(cfi_idx), .cfi_byte(cfi_byte)
  );

  // byte address with random alias bits and byte lane (R13)
  function automatic logic [11:0] baddr(int w);
    return 12'((($urandom % 4) * 1024) + w * 2 + ($urandom % 2));
  endfunction

  function automatic logic [15:0] stat_exp(logic [15:0] d, bit second);
    return {8'h00, ~d[7], second, 6'b0};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int w, logic [15:0] d);
    @(negedge clk); addr = baddr(w); wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(int w, output logic [15:0] q);
    @(negedge clk); addr = baddr(w); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; q = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(UA, 16'h00AA); wr(UB, 16'h0055);
  endtask

  task automatic expect_word(int w, string req);
    logic [15:0] q;
    rd(w, q); chk(req, q, shadow[w]);
  endtask

  task automatic prog(int w, logic [15:0] d, bit byp);
    logic [15:0] q;
    if (!byp) begin unlock(); wr(UA, 16'h00A0); end
    else wr($urandom % WORDS, 16'h00A0);
    wr(w, d);
    rd(w, q); chk("R6 program status", q, stat_exp(d, 1'b0));
    rd(w, q); chk("R6 program toggle", q, stat_exp(d, 1'b1));
    idle(PROGC + 2);
    shadow[w] = shadow[w] & d;
  endtask

  task automatic sector_erase(int w);
    logic [15:0] q;
    unlock(); wr(UA, 16'h0080); unlock(); wr(w, 16'h0030);
    rd(w, q); chk("R6 erase status", q, 16'h0000);
    rd(w, q); chk("R6 erase toggle", q, 16'h0040);
    idle(SECTC + 3);
    for (int i = 0; i < SECW; i++) shadow[(w / SECW) * SECW + i] = 16'hFFFF;
  endtask

  initial begin
    #(20 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=%h expected=%h", 16'h0, 16'h1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] q;
    int bad;
    void'($urandom(32'd2024));
    idle(3); rst = 1'b0; idle(2);

    // R8/R9: chip erase, writes ignored while busy
    unlock(); wr(UA, 16'h0080); unlock(); wr(UA, 16'h0010);
    rd(3, q); chk("R6 chip status", q, 16'h0000);
    unlock(); wr(UA, 16'h00A0); wr(3, 16'h0000); wr(0, 16'h00F0);
    rd(3, q); chk("R6 chip toggle", q, 16'h0040);
    idle(CHIPC + 3);
    for (int i = 0; i < WORDS; i++) shadow[i] = 16'hFFFF;
    bad = 0;
    for (int i = 0; i < WORDS; i += 37) begin rd(i, q); if (q !== 16'hFFFF) bad++; end
    chk("R8 chip filled with ones", 16'(bad), 16'h0);
    expect_word(3, "R9 write during erase ignored");

    // R5: program and AND with old contents
    prog(10, 16'h1234, 1'b0);
    expect_word(10, "R5 program");
    prog(10, 16'hFF0F, 1'b0);
    chk("R5 and with old", shadow[10], 16'h1204);
    expect_word(10, "R5 program again");

    // R1: reset discards a pending program
    unlock(); wr(UA, 16'h00A0);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    wr(7, 16'h0000);
    expect_word(7, "R1 reset discards sequence");

    // R2: wrong second unlock
    wr(UA, 16'h00AA); wr(UB, 16'h0056); wr(UA, 16'h00A0); wr(20, 16'h0000);
    expect_word(20, "R2 bad unlock");

    // R3: unknown code, then wrong third address
    unlock(); wr(UA, 16'h0077); wr(UA, 16'h00A0); wr(21, 16'h0000);
    expect_word(21, "R3 unknown code");
    unlock(); wr(UA + 1, 16'h00A0); wr(22, 16'h0000);
    expect_word(22, "R3 wrong command address");

    // R4: abort mid sequence; exception when data is pending
    unlock(); wr(5, 16'h00F0); wr(UA, 16'h00A0); wr(23, 16'h0000);
    expect_word(23, "R4 abort");
    prog(24, 16'h00F0, 1'b0);
    expect_word(24, "R4 abort code programmed as data");

    // R7: sector erase at arbitrary word in sector 1
    prog(SECW + 5, 16'h0F0F, 1'b0);
    prog(2 * SECW + 9, 16'h3C3C, 1'b0);
    sector_erase(SECW + 77);
    bad = 0;
    for (int i = SECW; i < 2 * SECW; i += 11) begin rd(i, q); if (q !== 16'hFFFF) bad++; end
    chk("R7 sector filled", 16'(bad), 16'h0);
    expect_word(2 * SECW + 9, "R7 other sector kept");
    expect_word(10, "R7 sector 0 kept");

    // R8: chip-erase code at wrong offset
    unlock(); wr(UA, 16'h0080); unlock(); wr(UA + 2, 16'h0010);
    expect_word(10, "R8 misplaced chip erase");

    // R10: identifier mode
    prog(5, 16'h5A5A, 1'b0); prog(15, 16'h7777, 1'b0);
    unlock(); wr(UA, 16'h0090);
    rd(0, q); chk("R10 id0", q, IDM);
    rd(1, q); chk("R10 id1", q, IDD);
    rd(2, q); chk("R10 protect", q, 16'h0000);
    rd(14, q); chk("R10 ext0", q, IDX0);
    rd(15, q); chk("R10 ext1 all ones falls back", q, shadow[15]);
    rd(5, q); chk("R10 other offset", q, shadow[5]);

    // R11: query from identifier mode
    wr(QOFF, 16'h0098);
    rd(16, q); chk("R11 query byte", q, 16'(8'h10 ^ 8'h5A));
    rd(CFIL + 5, q); chk("R11 past table", q, 16'h0000);
    wr(0, 16'h0000);
    expect_word(5, "R11 write exits query");

    // R11/R13: query from read mode, sector-local offset in sector 2
    wr(2 * SECW + QOFF, 16'h0098);
    rd(CFIL - 1, q); chk("R11 last index", q, 16'(8'(CFIL - 1) ^ 8'h5A));
    wr(0, 16'h00F0);
    expect_word(10, "R11 back to array");

    // R12: bypass
    unlock(); wr(UA, 16'h0020);
    prog(30, 16'hAAAA, 1'b1);
    prog(31, 16'h0101, 1'b1);
    expect_word(30, "R12 bypass program");
    expect_word(31, "R12 stays in bypass");
    wr(3, 16'h0090); wr(3, 16'h0000);
    wr(UA, 16'h00A0); wr(32, 16'h0000);
    expect_word(32, "R12 bypass exited");

    // R13: aliasing through random upper and lane bits
    prog(100, 16'hBEEF, 1'b0);
    expect_word(100, "R13 alias read");
    expect_word(100, "R13 alias read again");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int w;
      logic [15:0] d;
      w = $urandom % WORDS;
      d = 16'($urandom);
      if (d[7:0] == 8'hF0) d[7:0] = 8'h0F;
      if (it % 3 == 0) begin
        unlock(); wr(UA, 16'h0020);
        prog(w, d, 1'b1);
        wr(0, 16'h0090); wr(0, 16'h0000);
      end else begin
        prog(w, d, 1'b0);
      end
      wr($urandom % WORDS, 16'h0011);
      expect_word(w, "R5 random program");
      expect_word($urandom % WORDS, "R13 random read");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule